// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between an on-chip request/acknowledge port and an external asynchronous static RAM. The RAM is built from four 8-bit lanes, each with its own active-low chip select and write enable. All four lanes share one 19-bit row address and one active-low output enable. The controller turns each host request into a sequence of strobes. The length of every phase of that sequence is a whole number of clocks, derived from nanosecond timing parameters and the clock period.

The same memory can be used three ways, chosen per request by a mode input. It can be one 32-bit word per row. It can be two 16-bit halves per row, with host address bit 19 choosing the half. It can be four bytes per row, with host address bits 20:19 choosing the byte. In the narrow modes, write data is copied onto every lane of the bus, and only the chosen lanes are strobed. Read data comes back zero-extended in the low bits. The bidirectional data bus is modelled as a separate input, a separate output and an output-enable.

Top module: `asram_lane_ctrl`

## Requirements
- R1: After reset, all chip selects, write enables and the output enable are high. The data bus is not driven, the acknowledge is low, the ready output is high and the read data output is zero.
- R2: Mode code 0 (mode code 3 acts the same) writes and reads all four lanes. Write data bits 8k+7:8k go to lane k. A read returns the full 32-bit word that was stored.
- R3: In mode code 1, host address bit 19 selects lanes 1:0 when it is 0 and lanes 3:2 when it is 1. The write bus carries the low 16 data bits on both halves. A read returns the selected half in bits 15:0, with zeros above.
- R4: In mode code 2, host address bits 20:19 select a single lane. The write bus carries the low data byte on all four lanes. A read returns the selected lane's byte in bits 7:0, with zeros above.
- R5: During a write, the chip selects and write enables of exactly the selected lanes are low, and the output enable stays high. The write enable is never low on a lane whose chip select is high.
- R6: The write enable rises one cycle before the row address or bus data may change, and the bus is still driven in that cycle. The bus is driven only while a write enable is low or in that following cycle.
- R7: During a read, the output enable and the selected lanes' chip selects are low. Data is captured in the last cycle of the read phase.
- R8: Before the bus is driven, the output enable has been high for at least the output-float phase length. If a write follows a read too closely, idle cycles are inserted to make this true.
- R9: The acknowledge is a one-cycle pulse. Read data is valid in the acknowledge cycle. Counting from the accepting clock edge, the acknowledge arrives in cycle WR+2 for a write and RD+1 for a read, plus any float cycles inserted under R8.
- R10: A request is accepted only while ready is high, and ready is high only when the controller is idle. A request held during a busy operation leaves the memory unchanged.
- R11: Each phase lasts ceil(t/CLK_NS) cycles, with a minimum of 1. The write phase WR is the largest of the write-pulse phase, the data-setup phase and the cycle-time phase minus one. The read phase RD is the larger of the address-access phase and the output-enable-access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Width code: 0/3 = 32-bit, 1 = 16-bit, 2 = 8-bit |
| req_addr | input | 21 | Host address: row in 18:0, lane select in 20:19 |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_ack | output | 1 | Operation finished, one-cycle pulse |
| rsp_rdata | output | 32 | Read data, valid with the acknowledge |
| ram_addr | output | 19 | Shared row address |
| ram_cs_n | output | 4 | Per-lane chip select, active low |
| ram_we_n | output | 4 | Per-lane write enable, active low |
| ram_oe_n | output | 1 | Shared output enable, active low |
| ram_dq_out | output | 32 | Data toward the memory |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |
| ram_dq_in | input | 32 | Data from the memory |

## Verification
The properties assume that reset is held high from time zero until the first clock edges have passed, and that the memory side only returns data and never drives strobes. No host-side protocol is assumed. The stimulus holds reset for three clocks and changes inputs only on falling edges. It offers a request only after ready has been seen high, except for one deliberate probe that holds a write request during a busy read. The random part draws every mode code, including the spare code, along with full addresses and data. Requests go out back to back, so writes follow reads at the shortest allowed distance.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int HALF_W = DATA_W / 2;
    localparam int ROW_W  = 19;
    localparam int HADR_W = ROW_W + 2;

    typedef enum logic [1:0] {
        WIDTH32 = 2'd0,
        WIDTH16 = 2'd1,
        WIDTH8  = 2'd2
    } width_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_TURN,
        SEQ_WRITE,
        SEQ_GUARD,
        SEQ_READ,
        SEQ_ACK
    } seq_e;

    typedef struct packed {
        width_e             width;
        logic [1:0]         sel;
        logic [LANES-1:0]   lanes;
        logic [ROW_W-1:0]   row;
        logic [DATA_W-1:0]  bus;
    } xfer_t;

    // Cycles needed to cover t_ns, never less than one.
    function automatic int phase_cycles(int t_ns, int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Pick the addressed lanes out of the bus and zero-extend them.
    function automatic logic [DATA_W-1:0] gather(width_e w, logic [1:0] sel,
                                                 logic [DATA_W-1:0] dq);
        case (w)
            WIDTH16: return sel[0] ? {{HALF_W{1'b0}}, dq[DATA_W-1:HALF_W]}
                                   : {{HALF_W{1'b0}}, dq[HALF_W-1:0]};
            WIDTH8:  return {{(DATA_W-LANE_W){1'b0}}, dq[sel*LANE_W +: LANE_W]};
            default: return dq;
        endcase
    endfunction

endpackage

// File: rtl/asram_steer.sv
module asram_steer
    import asram_pkg::*;
(
    input  width_e              width,
    input  logic [HADR_W-1:0]   haddr,
    input  logic [DATA_W-1:0]   wdata,
    output xfer_t               xfer
);
    always_comb begin
        xfer.width = width;
        xfer.row   = haddr[ROW_W-1:0];
        case (width)
            WIDTH16: begin
                xfer.sel   = {1'b0, haddr[ROW_W]};
                xfer.lanes = haddr[ROW_W] ? 4'b1100 : 4'b0011;
                xfer.bus   = {2{wdata[HALF_W-1:0]}};
            end
            WIDTH8: begin
                xfer.sel   = haddr[HADR_W-1:ROW_W];
                xfer.lanes = LANES'(1) << haddr[HADR_W-1:ROW_W];
                xfer.bus   = {LANES{wdata[LANE_W-1:0]}};
            end
            default: begin
                xfer.sel   = 2'd0;
                xfer.lanes = '1;
                xfer.bus   = wdata;
            end
        endcase
    end
endmodule

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int WR_CYC = 1,
    parameter int RD_CYC = 1,
    parameter int HZ_CYC = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic start_write,
    output logic ready,
    output logic ack,
    output logic cs_on,
    output logic we_on,
    output logic oe_on,
    output logic drive,
    output logic capture
);
    localparam int CW = $clog2(imax(WR_CYC, RD_CYC) + 1);
    localparam int FW = $clog2(HZ_CYC + 1);

    seq_e          st;
    logic [CW-1:0] cnt;
    logic [FW-1:0] flt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
            flt <= '0;
        end else begin
            if (flt != '0) flt <= flt - 1'b1;
            case (st)
                SEQ_IDLE: if (start) begin
                    cnt <= '0;
                    if (!start_write)   st <= SEQ_READ;
                    else if (flt != '0) st <= SEQ_TURN;
                    else                st <= SEQ_WRITE;
                end
                SEQ_TURN: if (flt == '0) st <= SEQ_WRITE;
                SEQ_WRITE: begin
                    if (cnt == CW'(WR_CYC - 1)) begin
                        st  <= SEQ_GUARD;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_GUARD: st <= SEQ_ACK;
                SEQ_READ: begin
                    if (cnt == CW'(RD_CYC - 1)) begin
                        st  <= SEQ_ACK;
                        cnt <= '0;
                        flt <= FW'(HZ_CYC - 1);
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_ACK: st <= SEQ_IDLE;
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ready   = (st == SEQ_IDLE);
        ack     = (st == SEQ_ACK);
        we_on   = (st == SEQ_WRITE);
        oe_on   = (st == SEQ_READ);
        drive   = (st == SEQ_WRITE) || (st == SEQ_GUARD);
        cs_on   = drive || oe_on;
        capture = oe_on && (cnt == CW'(RD_CYC - 1));
    end
endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl
    import asram_pkg::*;
#(
    parameter int CLK_NS = 20,
    parameter int T_WC   = 12,
    parameter int T_WP   = 10,
    parameter int T_DW   = 8,
    parameter int T_AA   = 12,
    parameter int T_OE   = 7,
    parameter int T_HZ   = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_mode,
    input  logic [HADR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                req_ack,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ROW_W-1:0]    ram_addr,
    output logic [LANES-1:0]    ram_cs_n,
    output logic [LANES-1:0]    ram_we_n,
    output logic                ram_oe_n,
    output logic [DATA_W-1:0]   ram_dq_out,
    output logic                ram_dq_oe,
    input  logic [DATA_W-1:0]   ram_dq_in
);
    localparam int WR_CYC = imax(imax(phase_cycles(T_WP, CLK_NS),
                                      phase_cycles(T_DW, CLK_NS)),
                                 phase_cycles(T_WC, CLK_NS) - 1);
    localparam int RD_CYC = imax(phase_cycles(T_AA, CLK_NS),
                                 phase_cycles(T_OE, CLK_NS));
    localparam int HZ_CYC = phase_cycles(T_HZ, CLK_NS);

    xfer_t             nxt, xf;
    logic [DATA_W-1:0] rdata_q;
    logic              accept, cs_on, we_on, oe_on, drive, capture;

    asram_steer u_steer (
        .width (width_e'(req_mode)),
        .haddr (req_addr),
        .wdata (req_wdata),
        .xfer  (nxt)
    );

    asram_seq #(
        .WR_CYC (WR_CYC),
        .RD_CYC (RD_CYC),
        .HZ_CYC (HZ_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (accept),
        .start_write (req_write),
        .ready       (req_ready),
        .ack         (req_ack),
        .cs_on       (cs_on),
        .we_on       (we_on),
        .oe_on       (oe_on),
        .drive       (drive),
        .capture     (capture)
    );

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            xf      <= '0;
            rdata_q <= '0;
        end else begin
            if (accept)  xf      <= nxt;
            if (capture) rdata_q <= gather(xf.width, xf.sel, ram_dq_in);
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign ram_cs_n[l] = ~(xf.lanes[l] & cs_on);
        assign ram_we_n[l] = ~(xf.lanes[l] & we_on);
    end

    assign ram_oe_n   = ~oe_on;
    assign ram_addr   = xf.row;
    assign ram_dq_out = xf.bus;
    assign ram_dq_oe  = drive;
    assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/asram_lane_chk.sv
module asram_lane_chk #(
    parameter int WR_CYC = 1,
    parameter int HZ_CYC = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        req_ack,
    input logic        req_ready,
    input logic [3:0]  ram_cs_n,
    input logic [3:0]  ram_we_n,
    input logic        ram_oe_n,
    input logic        ram_dq_oe,
    input logic [18:0] ram_addr,
    input logic [31:0] ram_dq_out
);
    int   wr_run;
    int   hz_run;
    logic dq_oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_run  <= 0;
            hz_run  <= HZ_CYC;
            dq_oe_q <= 1'b0;
        end else begin
            wr_run  <= (ram_we_n != 4'hF) ? wr_run + 1 : 0;
            dq_oe_q <= ram_dq_oe;
            if (!ram_oe_n)           hz_run <= 0;
            else if (hz_run < HZ_CYC) hz_run <= hz_run + 1;
        end
    end

    // R5
    we_in_cs_chk: assert property (@(posedge clk) disable iff (rst)
        ((~ram_we_n & ram_cs_n) == 4'h0));
    // R5
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we_n != 4'hF) |-> ram_oe_n);
    // R2
    cs_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(~ram_cs_n) != 3));
    // R6
    drive_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> ram_oe_n);
    // R6
    guard_drive_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ram_we_n) != 4'hF && ram_we_n == 4'hF) |-> ram_dq_oe);
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ram_we_n) != 4'hF && ram_we_n != 4'hF)
            |-> ($stable(ram_addr) && $stable(ram_dq_out)));
    // R11
    wr_len_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_we_n == 4'hF && wr_run != 0) |-> (wr_run == WR_CYC));
    // R8
    float_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_dq_oe && !dq_oe_q) |-> (hz_run >= HZ_CYC));
    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);
    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (ram_cs_n != 4'hF || req_ack) |-> !req_ready);
endmodule

bind asram_lane_ctrl asram_lane_chk #(
    .WR_CYC (WR_CYC),
    .HZ_CYC (HZ_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ack    (req_ack),
    .req_ready  (req_ready),
    .ram_cs_n   (ram_cs_n),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_dq_oe  (ram_dq_oe),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out)
);

// File: tb/asram_lane_ctrl_test.sv
module asram_lane_ctrl_test;

    localparam int CLKNS = 5;
    localparam int THZ   = 12;

    function automatic int cdiv(int t);
        int c;
        c = (t + CLKNS - 1) / CLKNS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_WR = mx(mx(cdiv(10), cdiv(8)), cdiv(12) - 1);
    localparam int EXP_RD = mx(cdiv(12), cdiv(7));
    localparam int EXP_HZ = cdiv(THZ);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, req_ack;
    logic [31:0] rsp_rdata;
    logic [18:0] ram_addr;
    logic [3:0]  ram_cs_n, ram_we_n;
    logic        ram_oe_n, ram_dq_oe;
    logic [31:0] ram_dq_out, ram_dq_in;

    asram_lane_ctrl #(.CLK_NS(CLKNS), .T_HZ(THZ)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    always #10 clk = ~clk;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;
    bit  mon_on = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Memory model and reference contents (rows aliased to 8 bits in both).
    logic [7:0] sram [4][256];
    logic [7:0] refm [4][256];

    always @(posedge clk)
        for (int l = 0; l < 4; l++)
            if (!ram_cs_n[l] && !ram_we_n[l]) sram[l][ram_addr[7:0]] <= ram_dq_out[l*8 +: 8];

    always_comb
        for (int l = 0; l < 4; l++)
            ram_dq_in[l*8 +: 8] = (!ram_cs_n[l] && !ram_oe_n && ram_we_n[l])
                                  ? sram[l][ram_addr[7:0]] : 8'hA5;

    function automatic logic [3:0] exp_mask(input logic [1:0] m, input logic [20:0] a);
        if (m == 2'd1) return a[19] ? 4'b1100 : 4'b0011;
        if (m == 2'd2) return 4'b0001 << a[20:19];
        return 4'b1111;
    endfunction
    function automatic logic [31:0] exp_bus(input logic [1:0] m, input logic [31:0] d);
        if (m == 2'd1) return {2{d[15:0]}};
        if (m == 2'd2) return {4{d[7:0]}};
        return d;
    endfunction
    function automatic logic [31:0] exp_read(input logic [1:0] m, input logic [20:0] a);
        logic [7:0] r;
        r = a[7:0];
        if (m == 2'd1)
            return a[19] ? {16'h0, refm[3][r], refm[2][r]} : {16'h0, refm[1][r], refm[0][r]};
        if (m == 2'd2) return {24'h0, refm[a[20:19]][r]};
        return {refm[3][r], refm[2][r], refm[1][r], refm[0][r]};
    endfunction

    logic [3:0]  cur_mask = '0;
    logic [31:0] cur_bus = '0;
    int  wrun = 0, rrun = 0, hz = 100;
    logic dq_oe_p = 1'b0;
    logic [3:0] we_p = 4'hF;

    // Strobe monitor: R5, R6, R7, R8, R11.
    always @(negedge clk) begin
        if (mon_on) begin
            if (ram_we_n != 4'hF) begin
                wrun++;
                chk(~ram_we_n == cur_mask && ~ram_cs_n == cur_mask, "R5 write lanes",
                    {28'h0, ~ram_we_n}, {28'h0, cur_mask});
                chk(ram_oe_n, "R5 oe high in write", {31'h0, ram_oe_n}, 32'h1);
                chk(ram_dq_out == cur_bus, "R2/R3/R4 write bus", ram_dq_out, cur_bus);
            end else if (wrun != 0) begin
                chk(wrun == EXP_WR, "R11 write phase", wrun, EXP_WR);
                chk(ram_dq_oe, "R6 guard drive", {31'h0, ram_dq_oe}, 32'h1);
                wrun = 0;
            end
            if (!ram_oe_n) begin
                rrun++;
                chk(~ram_cs_n == cur_mask, "R7 read lanes", {28'h0, ~ram_cs_n}, {28'h0, cur_mask});
            end else if (rrun != 0) begin
                chk(rrun == EXP_RD, "R11 read phase", rrun, EXP_RD);
                rrun = 0;
            end
            if (ram_dq_oe && !dq_oe_p)
                chk(hz >= EXP_HZ, "R8 float gap", hz, EXP_HZ);
            if (ram_dq_oe && ram_we_n == 4'hF && we_p == 4'hF)
                chk(1'b0, "R6 drive outside write", 32'h1, 32'h0);
            if (!ram_oe_n) hz = 0;
            else if (hz < 100) hz++;
            dq_oe_p = ram_dq_oe;
            we_p    = ram_we_n;
        end
    end

    bit prev_read = 1'b0;

    task automatic do_op(input bit wr, input logic [1:0] m, input logic [20:0] a,
                         input logic [31:0] d, input bit poke);
        int lat, guard_n, exp_lat;
        guard_n = 0;
        while (!req_ready && guard_n < 50) begin @(negedge clk); guard_n++; end
        cur_mask = exp_mask(m, a);
        cur_bus  = exp_bus(m, d);
        req_valid = 1'b1; req_write = wr; req_mode = m; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        if (poke) begin
            // R10: hold a write to another row while busy.
            req_write = 1'b1; req_mode = 2'd0; req_addr = 21'h0000F0; req_wdata = 32'hDEADBEEF;
            chk(!req_ready, "R10 ready low when busy", {31'h0, req_ready}, 32'h0);
        end else begin
            req_valid = 1'b0;
        end
        lat = 1;
        while (!req_ack && lat < 60) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 2) begin
                chk(!req_ready, "R10 ready low when busy", {31'h0, req_ready}, 32'h0);
                req_valid = 1'b0;
            end
        end
        exp_lat = wr ? EXP_WR + 2 + ((prev_read) ? mx(0, EXP_HZ - 2) : 0) : EXP_RD + 1;
        chk(lat == exp_lat, "R9 ack latency", lat, exp_lat);
        if (wr) begin
            for (int l = 0; l < 4; l++)
                if (cur_mask[l]) refm[l][a[7:0]] = cur_bus[l*8 +: 8];
        end else begin
            chk(rsp_rdata == exp_read(m, a),
                (m == 2'd1) ? "R3 read data" : (m == 2'd2) ? "R4 read data" : "R2 read data",
                rsp_rdata, exp_read(m, a));
        end
        @(negedge clk);
        chk(!req_ack, "R9 ack single cycle", {31'h0, req_ack}, 32'h0);
        prev_read = !wr;
    endtask

    initial begin
        for (int l = 0; l < 4; l++)
            for (int r = 0; r < 256; r++) begin
                sram[l][r] = 8'h00;
                refm[l][r] = 8'h00;
            end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1
        chk(ram_cs_n == 4'hF && ram_we_n == 4'hF && ram_oe_n && !ram_dq_oe,
            "R1 strobes idle", {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, 10'h3FE);
        chk(!req_ack && req_ready, "R1 handshake", {req_ack, req_ready}, 2'b01);
        chk(rsp_rdata == 32'h0, "R1 rdata", rsp_rdata, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;

        // R2: 32-bit, spare code 3 as well
        do_op(1'b1, 2'd0, 21'h000011, 32'h11223344, 1'b0);
        do_op(1'b0, 2'd0, 21'h000011, 32'h0, 1'b0);
        do_op(1'b1, 2'd3, 21'h000012, 32'hCAFEF00D, 1'b0);
        do_op(1'b0, 2'd0, 21'h000012, 32'h0, 1'b0);
        // R3: both halves, other half untouched
        do_op(1'b1, 2'd1, 21'h080011, 32'hFFFF5A6B, 1'b0);
        do_op(1'b0, 2'd1, 21'h080011, 32'h0, 1'b0);
        do_op(1'b0, 2'd1, 21'h000011, 32'h0, 1'b0);
        do_op(1'b0, 2'd0, 21'h000011, 32'h0, 1'b0);
        // R4: every lane
        for (int s = 0; s < 4; s++)
            do_op(1'b1, 2'd2, {s[1:0], 19'h00020}, 32'h10 + s, 1'b0);
        for (int s = 0; s < 4; s++)
            do_op(1'b0, 2'd2, {s[1:0], 19'h00020}, 32'h0, 1'b0);
        do_op(1'b0, 2'd0, 21'h000020, 32'h0, 1'b0);
        // R10: write held during a read is dropped
        do_op(1'b1, 2'd0, 21'h0000F0, 32'h01020304, 1'b0);
        do_op(1'b0, 2'd0, 21'h000011, 32'h0, 1'b1);
        do_op(1'b0, 2'd0, 21'h0000F0, 32'h0, 1'b0);

        // Random mix, back to back (R2, R3, R4, R8, R9)
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  m;
            logic [20:0] a;
            m = 2'($urandom % 4);
            a = 21'($urandom);
            do_op(1'($urandom % 2), m, a, $urandom, 1'b0);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

endmodule